// File: doc/BRIEF.md
# Mailbox Peripheral Clock-Enable Controller

This block produces one clock-enable strobe for each of up to 32 peripherals. Each strobe is derived from the master clock and divided by 1, 2, 4 or 8. Each peripheral's strobe can also be switched off on its own. Software does not see one register per peripheral. It reaches every setting through a single 32-bit mailbox word. A written word carries a peripheral number, a command bit, a divide code and an enable bit. A write command stores the enable and the divide code for the numbered peripheral. A read command fetches that peripheral's stored settings into the readable mailbox.

The mailbox is run by a two-state machine. In MB_IDLE, a write strobe on the mailbox takes the word into a command register (transition ACCEPT, MB_IDLE to MB_EXEC). In MB_EXEC, the command is carried out and the readback word is loaded. The machine then always returns to MB_IDLE (transition COMPLETE, MB_EXEC to MB_IDLE).

All peripherals share one free-running 3-bit counter, so every peripheral with the same divide code ticks in phase. A stored setting becomes live only at the end of a period of the setting that is live at that moment. This means a strobe pattern is never cut short or stretched mid-period. The strobes are meant to drive clock-gating cells elsewhere.

Top module: `pclk_mailbox_ctrl`

## Requirements
- R1: After reset every stored enable is 0, every stored divide code is 00, mb_rdata is all zeros and every strobe is low.
- R2: Mailbox word fields are: bits [5:0] peripheral number; bit 12 command (1 = write, 0 = read); bits [17:16] divide code (00 = /1, 01 = /2, 10 = /4, 11 = /8); bit 28 enable. Every other bit of the written word is ignored, and every other bit of mb_rdata reads 0.
- R3: A word presented with mb_wr high in MB_IDLE is taken at that clock edge, and the command is carried out at the next edge. From that next edge on, mb_rdata holds three things: the word's peripheral number and command bit, plus the addressed peripheral's enable and divide code as stored once the command has been applied. mb_rdata changes at no other edge.
- R4: A write command with a peripheral number below NUM_PERIPH changes the stored enable and divide code of that peripheral only. A read command changes no stored setting.
- R5: A command whose peripheral number is NUM_PERIPH or above changes no stored setting. Its readback has enable 0 and divide code 00.
- R6: mb_wr high during the MB_EXEC cycle is ignored. That word is neither stored nor carried out.
- R7: A shared 3-bit counter is 0 after reset and counts up by one every clock. While its live setting is enabled with divide code k, a peripheral's strobe is high in exactly those cycles in which the low k counter bits are all ones. So /1 is high every cycle, /2 on odd counts, /4 on counts 3 and 7, and /8 on count 7.
- R8: A peripheral's stored setting becomes its live setting only at a clock edge that ends a cycle in which the low bits of the counter, as selected by the current live code, are all ones. Until then the previous live setting keeps driving the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_wr | input | 1 | Mailbox write strobe |
| mb_wdata | input | 32 | Mailbox word written by software |
| mb_rdata | output | 32 | Mailbox readback word |
| periph_clk_en | output | NUM_PERIPH | One clock-enable strobe per peripheral |

## Verification
Take the edge at which a word is accepted as edge t. mb_rdata and the stored table change at edge t+1. A live strobe setting changes at the first qualifying boundary edge after t+1, and the new strobe pattern starts in the cycle after that edge. The bench drives inputs on falling edges and keeps a behavioural model that steps on each rising edge. It compares mb_rdata and every strobe at each falling edge, so each result is sampled half a cycle after the edge that produces it. The directed checks wait the two edges of a mailbox command before reading mb_rdata. They let the boundary-delayed settings settle for two full /8 periods before counting strobes over an 8-cycle window.

// File: rtl/pclk_mb_pkg.sv
package pclk_mb_pkg;

    localparam int MB_W       = 32;
    localparam int MB_ID_W    = 6;
    localparam int MB_ID_LSB  = 0;
    localparam int MB_CMD_BIT = 12;
    localparam int MB_DIV_LSB = 16;
    localparam int MB_EN_BIT  = 28;
    localparam int DIV_CODE_W = 2;
    localparam int DIV_CNT_W  = 3;

    localparam logic [MB_W-1:0] MB_FIELD_MASK = 32'h1003_103F;

    typedef logic [DIV_CODE_W-1:0] div_code_t;
    typedef logic [MB_ID_W-1:0]    periph_id_t;

    typedef enum logic {
        MB_IDLE = 1'b0,
        MB_EXEC = 1'b1
    } mb_state_e;

    // Low-bit mask of the shared counter selected by a divide code
    function automatic logic [DIV_CNT_W-1:0] div_mask(input div_code_t code);
        return DIV_CNT_W'((1 << code) - 1);
    endfunction

    function automatic logic [MB_W-1:0] mb_pack(input periph_id_t id,
                                                input logic       wr,
                                                input div_code_t  code,
                                                input logic       en);
        logic [MB_W-1:0] w;
        w = '0;
        w[MB_ID_LSB +: MB_ID_W]     = id;
        w[MB_CMD_BIT]               = wr;
        w[MB_DIV_LSB +: DIV_CODE_W] = code;
        w[MB_EN_BIT]                = en;
        return w;
    endfunction

endpackage

// File: rtl/pclk_mb_fsm.sv
module pclk_mb_fsm
    import pclk_mb_pkg::*;
#(
    parameter int NUM = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mb_wr,
    input  logic [MB_W-1:0] mb_wdata,
    input  logic            look_en,
    input  div_code_t       look_div,
    output mb_state_e       state,
    output periph_id_t      cmd_id,
    output logic            cmd_wr,
    output logic            cmd_en,
    output div_code_t       cmd_div,
    output logic            tbl_we,
    output logic [MB_W-1:0] mb_rdata
);

    localparam logic [MB_ID_W:0] NUM_L = (MB_ID_W+1)'(NUM);

    mb_state_e st_q, st_d;
    logic      id_ok;
    logic      res_en;
    div_code_t res_div;

    assign id_ok = {1'b0, cmd_id} < NUM_L;
    assign state = st_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MB_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: ACCEPT and COMPLETE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MB_IDLE: if (mb_wr) st_d = MB_EXEC;
            MB_EXEC: st_d = MB_IDLE;
        endcase
    end

    // Command capture on ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_id  <= '0;
            cmd_wr  <= 1'b0;
            cmd_en  <= 1'b0;
            cmd_div <= '0;
        end else if (st_q == MB_IDLE && mb_wr) begin
            cmd_id  <= mb_wdata[MB_ID_LSB +: MB_ID_W];
            cmd_wr  <= mb_wdata[MB_CMD_BIT];
            cmd_en  <= mb_wdata[MB_EN_BIT];
            cmd_div <= mb_wdata[MB_DIV_LSB +: DIV_CODE_W];
        end
    end

    // Per-state outputs
    always_comb begin
        tbl_we  = 1'b0;
        res_en  = look_en;
        res_div = look_div;
        unique case (st_q)
            MB_IDLE: ;
            MB_EXEC: begin
                if (cmd_wr && id_ok) begin
                    tbl_we  = 1'b1;
                    res_en  = cmd_en;
                    res_div = cmd_div;
                end
            end
        endcase
    end

    // Readback word, loaded on COMPLETE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_rdata <= '0;
        end else if (st_q == MB_EXEC) begin
            mb_rdata <= mb_pack(cmd_id, cmd_wr, res_div, res_en);
        end
    end

endmodule

// File: rtl/pclk_mb_table.sv
module pclk_mb_table
    import pclk_mb_pkg::*;
#(
    parameter int NUM = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  periph_id_t                      wid,
    input  logic                            wen,
    input  div_code_t                       wdiv,
    input  periph_id_t                      rid,
    output logic                            ren,
    output div_code_t                       rdiv,
    output logic [NUM-1:0]                  en_vec,
    output logic [NUM-1:0][DIV_CODE_W-1:0]  div_vec
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_vec  <= '0;
            div_vec <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (we && wid == MB_ID_W'(i)) begin
                    en_vec[i]  <= wen;
                    div_vec[i] <= wdiv;
                end
            end
        end
    end

    // Lookup: numbers with no slot match nothing and read as zero
    always_comb begin
        ren  = 1'b0;
        rdiv = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rid == MB_ID_W'(i)) begin
                ren  = en_vec[i];
                rdiv = div_vec[i];
            end
        end
    end

endmodule

// File: rtl/pclk_mb_strobe.sv
module pclk_mb_strobe
    import pclk_mb_pkg::*;
#(
    parameter int NUM = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM-1:0]                  cfg_en,
    input  logic [NUM-1:0][DIV_CODE_W-1:0]  cfg_div,
    output logic [NUM-1:0]                  strobe
);

    logic [DIV_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_CNT_W'(1);
        end
    end

    for (genvar g = 0; g < NUM; g++) begin : g_ch
        logic                 act_en_q;
        div_code_t            act_div_q;
        logic [DIV_CNT_W-1:0] msk;
        logic                 bnd;

        assign msk = div_mask(act_div_q);
        assign bnd = (cnt_q & msk) == msk;

        // Live setting follows the stored one only at a period end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_en_q  <= 1'b0;
                act_div_q <= '0;
            end else if (bnd) begin
                act_en_q  <= cfg_en[g];
                act_div_q <= cfg_div[g];
            end
        end

        assign strobe[g] = act_en_q && bnd;
    end

endmodule

// File: rtl/pclk_mailbox_ctrl.sv
module pclk_mailbox_ctrl
    import pclk_mb_pkg::*;
#(
    parameter int NUM_PERIPH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mb_wr,
    input  logic [MB_W-1:0]       mb_wdata,
    output logic [MB_W-1:0]       mb_rdata,
    output logic [NUM_PERIPH-1:0] periph_clk_en
);

    mb_state_e                              st;
    periph_id_t                             cmd_id;
    logic                                   cmd_wr;
    logic                                   cmd_en;
    div_code_t                              cmd_div;
    logic                                   tbl_we;
    logic                                   look_en;
    div_code_t                              look_div;
    logic [NUM_PERIPH-1:0]                  tbl_en_vec;
    logic [NUM_PERIPH-1:0][DIV_CODE_W-1:0]  tbl_div_vec;

    pclk_mb_fsm #(.NUM(NUM_PERIPH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mb_wr    (mb_wr),
        .mb_wdata (mb_wdata),
        .look_en  (look_en),
        .look_div (look_div),
        .state    (st),
        .cmd_id   (cmd_id),
        .cmd_wr   (cmd_wr),
        .cmd_en   (cmd_en),
        .cmd_div  (cmd_div),
        .tbl_we   (tbl_we),
        .mb_rdata (mb_rdata)
    );

    pclk_mb_table #(.NUM(NUM_PERIPH)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .wid     (cmd_id),
        .wen     (cmd_en),
        .wdiv    (cmd_div),
        .rid     (cmd_id),
        .ren     (look_en),
        .rdiv    (look_div),
        .en_vec  (tbl_en_vec),
        .div_vec (tbl_div_vec)
    );

    pclk_mb_strobe #(.NUM(NUM_PERIPH)) u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (tbl_en_vec),
        .cfg_div (tbl_div_vec),
        .strobe  (periph_clk_en)
    );

endmodule

// File: rtl/pclk_mb_chk.sv
module pclk_mb_chk
    import pclk_mb_pkg::*;
#(
    parameter int NUM = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            mb_wr,
    input mb_state_e                       st,
    input periph_id_t                      cmd_id,
    input logic [MB_W-1:0]                 mb_rdata,
    input logic [NUM-1:0]                  tbl_en_vec,
    input logic [NUM-1:0][DIV_CODE_W-1:0]  tbl_div_vec
);

    localparam logic [MB_ID_W:0] NUM_L = (MB_ID_W+1)'(NUM);

    // R3: an idle write is always taken
    a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MB_IDLE && mb_wr) |=> (st == MB_EXEC));

    // R6: the execute cycle never lasts more than one clock
    a_r6_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MB_EXEC) |=> (st == MB_IDLE));

    // R3: readback moves only on the edge leaving MB_EXEC
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MB_IDLE) |=> $stable(mb_rdata));

    // R2: unused readback bits stay zero
    a_r2_rdata_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_rdata & ~MB_FIELD_MASK) == '0);

    // R5: out-of-range numbers leave the stored table untouched
    a_r5_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MB_EXEC && {1'b0, cmd_id} >= NUM_L)
        |=> ($stable(tbl_en_vec) && $stable(tbl_div_vec)));

endmodule

bind pclk_mailbox_ctrl pclk_mb_chk #(.NUM(NUM_PERIPH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mb_wr       (mb_wr),
    .st          (st),
    .cmd_id      (cmd_id),
    .mb_rdata    (mb_rdata),
    .tbl_en_vec  (tbl_en_vec),
    .tbl_div_vec (tbl_div_vec)
);

// File: tb/tb_pclk_mailbox_ctrl.sv
`timescale 1ns/1ps
module tb_pclk_mailbox_ctrl;

    localparam int NUM = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mb_wr = 1'b0;
    logic [31:0]     mb_wdata = '0;
    logic [31:0]     mb_rdata;
    logic [NUM-1:0]  periph_clk_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pclk_mailbox_ctrl #(.NUM_PERIPH(NUM)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mb_wr         (mb_wr),
        .mb_wdata      (mb_wdata),
        .mb_rdata      (mb_rdata),
        .periph_clk_en (periph_clk_en)
    );

    // Behavioural reference model, stepped on every rising edge
    int          m_en [NUM];
    int          m_div[NUM];
    int          a_en [NUM];
    int          a_div[NUM];
    int          m_cnt;
    bit          m_busy;
    logic [31:0] m_cmd;
    logic [31:0] m_rdata;

    function automatic int low_mask(input int code);
        return (1 << code) - 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                m_en[i] = 0; m_div[i] = 0; a_en[i] = 0; a_div[i] = 0;
            end
            m_cnt = 0; m_busy = 0; m_cmd = '0; m_rdata = '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if ((m_cnt & low_mask(a_div[i])) == low_mask(a_div[i])) begin
                    a_en[i]  = m_en[i];
                    a_div[i] = m_div[i];
                end
            end
            if (m_busy) begin
                int id, wr, e, d;
                id = int'(m_cmd[5:0]);
                wr = int'(m_cmd[12]);
                e = 0; d = 0;
                if (id < NUM) begin
                    if (wr == 1) begin
                        m_en[id]  = int'(m_cmd[28]);
                        m_div[id] = int'(m_cmd[17:16]);
                    end
                    e = m_en[id];
                    d = m_div[id];
                end
                m_rdata = 32'(id) | (32'(wr) << 12) | (32'(d) << 16) | (32'(e) << 28);
                m_busy = 0;
            end else if (mb_wr) begin
                m_cmd  = mb_wdata;
                m_busy = 1;
            end
            m_cnt = (m_cnt + 1) % 8;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NUM-1:0] exp_stb;
            for (int i = 0; i < NUM; i++) begin
                exp_stb[i] = (a_en[i] != 0) &&
                             ((m_cnt & low_mask(a_div[i])) == low_mask(a_div[i]));
            end
            check("R3 readback vs model", mb_rdata, m_rdata);
            check("R7 R8 strobes vs model", periph_clk_en, exp_stb);
        end
    end

    function automatic logic [31:0] word(input int id, input bit wr, input int dv, input bit en);
        return 32'(id) | (32'(wr) << 12) | (32'(dv) << 16) | (32'(en) << 28);
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk); mb_wr = 1'b1; mb_wdata = w;
        @(negedge clk); mb_wr = 1'b0; mb_wdata = '0;
        @(negedge clk);
    endtask

    task automatic count_ones(input int ch, output int n);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (periph_clk_en[ch]) n++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata after reset", mb_rdata, 32'h0);
        check("R1 strobes after reset", periph_clk_en, 32'h0);

        // R4: write peripheral 3, enable, /4
        send(word(3, 1, 2, 1));
        check("R4 write readback", mb_rdata, 32'h1002_1003);
        // R3: read back peripheral 3
        send(word(3, 0, 0, 0));
        check("R3 read of peripheral 3", mb_rdata, 32'h1002_0003);
        // R4: untouched neighbour stays at reset values
        send(word(4, 0, 0, 0));
        check("R4 neighbour unchanged", mb_rdata, 32'h0000_0004);

        // R5: number 35 is out of range (would alias slot 3 if truncated)
        send(word(35, 1, 3, 1));
        check("R5 out-of-range write readback", mb_rdata, 32'h0000_1023);
        send(word(3, 0, 0, 0));
        check("R5 no alias into slot 3", mb_rdata, 32'h1002_0003);
        send(word(35, 0, 0, 0));
        check("R5 out-of-range read", mb_rdata, 32'h0000_0023);

        // R2: unused bits in the word are ignored
        send(~32'h1003_103F | word(5, 1, 1, 1));
        check("R2 junk bits dropped", mb_rdata, 32'h1001_1005);

        // R6: second word during the execute cycle is dropped
        @(negedge clk); mb_wr = 1'b1; mb_wdata = word(6, 1, 0, 1);
        @(negedge clk); mb_wdata = word(7, 1, 0, 1);
        @(negedge clk); mb_wr = 1'b0; mb_wdata = '0;
        @(negedge clk);
        check("R6 first word applied", mb_rdata, 32'h1000_1006);
        send(word(7, 0, 0, 0));
        check("R6 busy word ignored", mb_rdata, 32'h0000_0007);

        // R7: strobe densities over one 8-cycle counter period
        repeat (16) @(negedge clk);
        count_ones(6, n);
        check("R7 div1 density", 32'(n), 32'd8);
        count_ones(5, n);
        check("R7 div2 density", 32'(n), 32'd4);
        count_ones(3, n);
        check("R7 div4 density", 32'(n), 32'd2);
        count_ones(4, n);
        check("R7 disabled channel silent", 32'(n), 32'd0);

        // R8: retune and disable mid-period; model checks every cycle
        send(word(3, 1, 3, 1));
        send(word(6, 1, 0, 0));
        send(word(5, 1, 3, 1));
        repeat (5) @(negedge clk);
        send(word(5, 1, 1, 1));
        repeat (16) @(negedge clk);
        count_ones(3, n);
        check("R8 div8 after retune", 32'(n), 32'd1);
        count_ones(6, n);
        check("R8 disabled after boundary", 32'(n), 32'd0);
        count_ones(5, n);
        check("R8 div2 after back-to-back change", 32'(n), 32'd4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule